// File: doc/BRIEF.md
# GPIO Interrupt Summary Aggregator

The block gathers the pending flags of a large GPIO bank into a compact summary. Each pin is grouped with three neighbours, and every group of four sets one summary bit. With the default of 184 pins this gives 46 summary bits. Software reads them through two 32-bit status words. It then visits only the groups that are flagged, instead of polling every pin.

A single interrupt line goes to the host, gated by a global enable in a master control word. Once the line has been delivered and has dropped again, it stays low until software writes an end-of-interrupt bit in the master word. New pending flags that arrive in the meantime therefore cannot re-trigger the host inside its handler. After the end-of-interrupt write, the line comes back at once if any group is still pending. The per-pin detection logic sits outside the block and is seen as a plain vector of pending inputs.

Top module: `gpio_irq_aggr`

## Requirements
- R1: Summary bit n is the OR of pending inputs 4n, 4n+1, 4n+2 and 4n+3. It is live (not latched): a read returns the pending inputs present in the cycle of the read strobe.
- R2: The word at byte offset 0x0 returns summary bits 31..0 in data bits 31..0. The word at offset 0x4 returns summary bits 45..32 in data bits 13..0, and its data bits 31..14 read 0.
- R3: Read data is registered. It appears on `bus_rdata` in the cycle after a read strobe and holds until the next read. Offset 0xC reads 0. Address bits 1..0 are ignored.
- R4: The master word at offset 0x8 has a global enable in bit 0, which is written and read back. The end-of-interrupt command is in bit 1; it is write-only and always reads 0.
- R5: While the global enable is 0, `irq_o` is 0. Writing enable 0 forces `irq_o` low in the cycle after the write.
- R6: With enable set and the line not held off, `irq_o` rises in the cycle after any summary bit becomes 1. It stays high while any summary bit is 1.
- R7: Once `irq_o` has been high and has fallen, it stays low even if summary bits become 1 again, until an end-of-interrupt write occurs.
- R8: An end-of-interrupt write (bit 1 set, bit 0 keeping enable 1) raises `irq_o` in the next cycle if any summary bit is 1. If none is set, the next summary bit to become 1 raises it as in R6.
- R9: Writes to offsets 0x0 and 0x4 have no effect: status reads still return the live summary.
- R10: After reset `irq_o` is 0, `bus_rdata` is 0, the enable is 0 and the line is not held off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_pend | input | 184 | Pending flag of each pin |
| bus_en | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt line to the host, active high |

## Verification
Every result of the block is due one clock edge after its cause. Read data follows the strobe by one edge. `irq_o` follows a change of the pending inputs, an enable write or an end-of-interrupt write by one edge. The bench drives all inputs on the falling edge, lets exactly one rising edge pass, and samples on the next falling edge. At that point it compares against a cycle model of the enable, hold-off and line state, which it updates once per rising edge from the requirement rules.

// File: rtl/gpio_aggr_pkg.sv
package gpio_aggr_pkg;
    localparam int REG_W  = 32;
    localparam int ADDR_W = 4;
    localparam int MST_EN_BIT  = 0;
    localparam int MST_EOI_BIT = 1;

    typedef enum logic [1:0] {
        SEL_STAT_LO = 2'd0,
        SEL_STAT_HI = 2'd1,
        SEL_MASTER  = 2'd2,
        SEL_NONE    = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic             rd;
        logic             wr;
        reg_sel_e         sel;
        logic [REG_W-1:0] wdata;
    } bus_req_t;

    function automatic reg_sel_e decode_sel(input logic [ADDR_W-1:0] addr);
        return reg_sel_e'(addr[3:2]);
    endfunction
endpackage

// File: rtl/gpio_aggr_reduce.sv
module gpio_aggr_reduce #(
    parameter int NUM_PINS = 184,
    parameter int GRP      = 4,
    parameter int NUM_SUM  = (NUM_PINS + GRP - 1) / GRP
) (
    input  logic [NUM_PINS-1:0] pend,
    output logic [NUM_SUM-1:0]  summary
);
    localparam int PADDED = NUM_SUM * GRP;

    logic [PADDED-1:0] pend_pad;
    assign pend_pad = PADDED'(pend);

    for (genvar g = 0; g < NUM_SUM; g++) begin : g_grp
        assign summary[g] = |pend_pad[g*GRP +: GRP];
    end
endmodule

// File: rtl/gpio_aggr_regs.sv
module gpio_aggr_regs
    import gpio_aggr_pkg::*;
#(
    parameter int NUM_SUM = 46
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_req_t         req,
    input  logic [NUM_SUM-1:0] summary,
    output logic [REG_W-1:0] rdata,
    output logic             en_q,
    output logic             en_nxt,
    output logic             eoi_pulse
);
    localparam int STAT_W = 2 * REG_W;

    logic [STAT_W-1:0] stat_all;
    logic [REG_W-1:0]  rd_word;
    logic              wr_mst;

    assign stat_all = STAT_W'(summary);

    always_comb begin
        wr_mst    = req.wr && (req.sel == SEL_MASTER);
        en_nxt    = wr_mst ? req.wdata[MST_EN_BIT] : en_q;
        eoi_pulse = wr_mst && req.wdata[MST_EOI_BIT];
    end

    always_comb begin
        rd_word = '0;
        unique case (req.sel)
            SEL_STAT_LO: rd_word = stat_all[REG_W-1:0];
            SEL_STAT_HI: rd_word = stat_all[STAT_W-1:REG_W];
            SEL_MASTER:  rd_word[MST_EN_BIT] = en_q;
            default:     rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= 1'b0;
            rdata <= '0;
        end else begin
            en_q <= en_nxt;
            if (req.rd) begin
                rdata <= rd_word;
            end
        end
    end
endmodule

// File: rtl/gpio_aggr_irq.sv
module gpio_aggr_irq (
    input  logic clk,
    input  logic rst,
    input  logic any_pend,
    input  logic en_nxt,
    input  logic eoi,
    output logic irq_q,
    output logic blocked_q
);
    logic irq_d;
    logic blocked_d;

    always_comb begin
        irq_d     = en_nxt && any_pend && (irq_q || !blocked_q || eoi);
        blocked_d = eoi ? 1'b0 : (blocked_q || irq_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q     <= 1'b0;
            blocked_q <= 1'b0;
        end else begin
            irq_q     <= irq_d;
            blocked_q <= blocked_d;
        end
    end
endmodule

// File: rtl/gpio_irq_aggr.sv
module gpio_irq_aggr
    import gpio_aggr_pkg::*;
#(
    parameter int NUM_PINS = 184,
    parameter int GRP      = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pin_pend,
    input  logic                bus_en,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [REG_W-1:0]    bus_wdata,
    output logic [REG_W-1:0]    bus_rdata,
    output logic                irq_o
);
    localparam int NUM_SUM = (NUM_PINS + GRP - 1) / GRP;

    bus_req_t            req;
    logic [NUM_SUM-1:0]  summary;
    logic                en_q;
    logic                en_nxt;
    logic                eoi_pulse;
    logic                blocked;

    always_comb begin
        req.rd    = bus_en && !bus_we;
        req.wr    = bus_en && bus_we;
        req.sel   = decode_sel(bus_addr);
        req.wdata = bus_wdata;
    end

    gpio_aggr_reduce #(.NUM_PINS(NUM_PINS), .GRP(GRP), .NUM_SUM(NUM_SUM)) reduce_i (
        .pend    (pin_pend),
        .summary (summary)
    );

    gpio_aggr_regs #(.NUM_SUM(NUM_SUM)) regs_i (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .summary   (summary),
        .rdata     (bus_rdata),
        .en_q      (en_q),
        .en_nxt    (en_nxt),
        .eoi_pulse (eoi_pulse)
    );

    gpio_aggr_irq irq_i (
        .clk       (clk),
        .rst       (rst),
        .any_pend  (|summary),
        .en_nxt    (en_nxt),
        .eoi       (eoi_pulse),
        .irq_q     (irq_o),
        .blocked_q (blocked)
    );
endmodule

// File: rtl/gpio_irq_aggr_chk.sv
module gpio_irq_aggr_chk #(
    parameter int NUM_PINS = 184
) (
    input logic                clk,
    input logic                rst,
    input logic [NUM_PINS-1:0] pin_pend,
    input logic                bus_en,
    input logic                bus_we,
    input logic [3:0]          bus_addr,
    input logic [31:0]         bus_wdata,
    input logic [31:0]         bus_rdata,
    input logic                irq_o,
    input logic                en_q,
    input logic                blocked,
    input logic                eoi_pulse
);
    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> $past(|pin_pend)); // R6

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> en_q); // R5

    AST_EOI_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_en && !bus_we && bus_addr[3:2] == 2'd2) |=> !bus_rdata[1]); // R4

    AST_HI_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_en && !bus_we && bus_addr[3:2] == 2'd1) |=> (bus_rdata[31:14] == 18'd0)); // R2

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_en && !bus_we && bus_addr[3:2] == 2'd3) |=> (bus_rdata == 32'd0)); // R3

    AST_HELD_OFF_LOW: assert property (@(posedge clk) disable iff (rst)
        (!irq_o && blocked && !eoi_pulse) |=> !irq_o); // R7

    AST_EOI_REARMS: assert property (@(posedge clk) disable iff (rst)
        (eoi_pulse && bus_wdata[0] && (|pin_pend)) |=> irq_o); // R8
endmodule

bind gpio_irq_aggr gpio_irq_aggr_chk #(.NUM_PINS(NUM_PINS)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .pin_pend  (pin_pend),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o),
    .en_q      (en_q),
    .blocked   (blocked),
    .eoi_pulse (eoi_pulse)
);

// File: tb/gpio_irq_aggr_tb_top.sv
module gpio_irq_aggr_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 184;
    localparam int NS = 46;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] pin_pend = '0;
    logic          bus_en = 1'b0;
    logic          bus_we = 1'b0;
    logic [3:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          irq_o;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    // cycle model state
    bit m_en, m_blk, m_irq;
    logic [31:0] last_rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_irq_aggr dut_i (
        .clk(clk), .rst(rst), .pin_pend(pin_pend), .bus_en(bus_en),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    function automatic logic [NS-1:0] exp_sum(input logic [NP-1:0] p);
        logic [NS-1:0] s;
        for (int n = 0; n < NS; n++) begin
            s[n] = p[4*n] | p[4*n+1] | p[4*n+2] | p[4*n+3];
        end
        return s;
    endfunction

    function automatic logic [31:0] exp_read(input logic [3:0] a, input logic [NP-1:0] p, input bit en);
        logic [NS-1:0] s;
        s = exp_sum(p);
        case (a[3:2])
            2'd0:    return s[31:0];
            2'd1:    return {18'd0, s[45:32]};
            2'd2:    return {31'd0, en};
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock cycle: drive at falling edge, update model at rising edge,
    // compare at the next falling edge
    task automatic cyc(input logic [NP-1:0] p, input bit wr, input bit rd,
                       input logic [3:0] a, input logic [31:0] d, input string tag);
        bit eoi, en_new, any;
        logic [31:0] er;
        pin_pend  = p;
        bus_en    = wr | rd;
        bus_we    = wr;
        bus_addr  = a;
        bus_wdata = d;
        @(posedge clk);
        er     = exp_read(a, p, m_en);
        eoi    = wr && a[3:2] == 2'd2 && d[1];
        en_new = (wr && a[3:2] == 2'd2) ? d[0] : m_en;
        any    = |exp_sum(p);
        m_blk  = eoi ? 1'b0 : (m_blk | m_irq);
        m_irq  = en_new && any && (m_irq || !eoi ? (m_irq || !m_blk_prev_or(eoi)) : 1'b1);
        m_en   = en_new;
        if (rd) last_rd = er;
        @(negedge clk);
        bus_en = 1'b0;
        bus_we = 1'b0;
        chk({tag, " irq R6 R7"}, {31'd0, irq_o}, {31'd0, m_irq});
        chk({tag, " rdata R3"}, bus_rdata, last_rd);
    endtask

    // hold-off before this cycle's update, kept aside by cyc
    bit blk_before;
    function automatic bit m_blk_prev_or(input bit eoi);
        return blk_before;
    endfunction

    task automatic step(input logic [NP-1:0] p, input bit wr, input bit rd,
                        input logic [3:0] a, input logic [31:0] d, input string tag);
        blk_before = m_blk;
        cyc(p, wr, rd, a, d, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog R10 actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [NP-1:0] p;
        void'($urandom(32'h5eed_0a7e));
        m_en = 0; m_blk = 0; m_irq = 0; last_rd = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk("R10 irq after reset", {31'd0, irq_o}, 32'd0);
        chk("R10 rdata after reset", bus_rdata, 32'd0);
        step('0, 0, 1, 4'h8, 0, "R10 master read");
        chk("R10 enable reads 0", bus_rdata, 32'd0);

        // R5: pending but disabled
        p = '0; p[5] = 1'b1; p[130] = 1'b1;
        step(p, 0, 1, 4'h0, 0, "R5 disabled");
        chk("R5 irq low while disabled", {31'd0, irq_o}, 32'd0);
        chk("R1 status lo group bits", bus_rdata, 32'h0000_0002);
        step(p, 0, 1, 4'h7, 0, "R1 hi read");
        chk("R1 status hi bit 0 (pin 130)", bus_rdata, 32'h0000_0001);

        // R2: top pin lands in hi bit 13
        p = '0; p[183] = 1'b1;
        step(p, 0, 1, 4'h4, 0, "R2 top pin");
        chk("R2 pin 183 -> hi bit 13", bus_rdata, 32'h0000_2000);
        step(p, 0, 1, 4'h0, 0, "R2 lo empty");
        chk("R2 lo clear", bus_rdata, 32'd0);
        p = '0; p[127] = 1'b1; p[128] = 1'b1;
        step(p, 0, 1, 4'h1, 0, "R1 boundary lo");
        chk("R1 pin 127 -> lo bit 31", bus_rdata, 32'h8000_0000);

        // R6: enable, line rises
        step(p, 1, 0, 4'h8, 32'h1, "R6 enable");
        chk("R6 irq high after enable", {31'd0, irq_o}, 32'd1);
        step(p, 0, 1, 4'h8, 0, "R4 master read");
        chk("R4 enable=1 eoi reads 0", bus_rdata, 32'd1);

        // R7: drop, new pending held off
        step('0, 0, 0, 4'h0, 0, "R7 clear");
        chk("R7 irq falls", {31'd0, irq_o}, 32'd0);
        p = '0; p[40] = 1'b1;
        step(p, 0, 0, 4'h0, 0, "R7 new pend");
        step(p, 0, 0, 4'h0, 0, "R7 hold");
        chk("R7 irq held off", {31'd0, irq_o}, 32'd0);

        // R8: eoi re-arms
        step(p, 1, 0, 4'h8, 32'h3, "R8 eoi");
        chk("R8 irq back after eoi", {31'd0, irq_o}, 32'd1);

        // R9: status write ignored
        step(p, 1, 0, 4'h0, 32'hffff_ffff, "R9 write lo");
        step(p, 1, 0, 4'h4, 32'hffff_ffff, "R9 write hi");
        step(p, 0, 1, 4'h0, 0, "R9 read lo");
        chk("R9 lo still live", bus_rdata, 32'h0000_0400);
        step(p, 0, 1, 4'hC, 0, "R3 unmapped");
        chk("R3 offset C reads 0", bus_rdata, 32'd0);
        step(p, 0, 0, 4'h0, 0, "R3 hold");
        chk("R3 rdata holds", bus_rdata, 32'd0);

        // R5: disable forces low
        step(p, 1, 0, 4'h8, 32'h0, "R5 disable");
        chk("R5 irq forced low", {31'd0, irq_o}, 32'd0);

        // R8: eoi with nothing pending, then new pending asserts
        step('0, 1, 0, 4'h8, 32'h3, "R8 eoi idle");
        p = '0; p[0] = 1'b1;
        step(p, 0, 0, 4'h0, 0, "R8 next pend");
        chk("R8 next pending raises irq", {31'd0, irq_o}, 32'd1);

        // random phase
        for (int i = 0; i < 400; i++) begin
            int kind;
            logic [3:0] a;
            logic [31:0] d;
            p = '0;
            for (int k = 0; k < 3; k++) begin
                if ($urandom % 2 == 0) p[$urandom % NP] = 1'b1;
            end
            kind = $urandom % 8;
            a = 4'($urandom % 16);
            d = (($urandom % 6) == 0) ? 32'h0 : {30'd0, 1'($urandom % 2), 1'b1};
            if (kind < 3)      step(p, 0, 0, a, 0, "rand idle");
            else if (kind < 6) step(p, 0, 1, a, 0, "rand read R1 R2");
            else               step(p, 1, 0, 4'h8, d, "rand write R4 R8");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule